// File: doc/BRIEF.md
# Carry-Select / Carry-Increment Adder

A purely combinational adder that returns the WIDTH-bit sum and the carry-out of two operands plus a carry-in. The operand bits are split into groups whose sizes grow from the least significant end towards the most significant end. The bottom group is a plain ripple chain fed by the carry-in. Every group above it works out its result for both possible incoming carries. The carry that actually arrives from the group below then picks one of the two results. Because the groups get larger going up, a larger group has more time to finish before its select signal arrives.

A build parameter chooses how the upper groups are built. The duplicated form holds two complete ripple adders per group, one with its carry tied low and one with it tied high, followed by a multiplexer. The increment form builds one generate/propagate stage and one sum XOR row per group. It forms running group generate and propagate terms, and the carry into bit i of a group whose lowest bit is j is G(i-1:j) OR (P(i-1:j) AND group carry-in). Both forms compute the same function.

Group sizing: the lowest group holds FIRST_SIZE bits and each group above it is one bit wider than the one below. The top group also takes any bits that remain, so with the default values (16 bits, first size 2) the groups cover bits [1:0], [4:2], [8:5] and [15:9].

Top module: `csa_adder`

## Requirements
- R1: With USE_INCREMENT = 0, {cout_o, sum_o} equals a_i + b_i + cin_i, computed in WIDTH+1 bits, for every input.
- R2: With USE_INCREMENT = 1, {cout_o, sum_o} equals a_i + b_i + cin_i, computed in WIDTH+1 bits, for every input.
- R3: Both settings of USE_INCREMENT give identical sum_o and cout_o for the same inputs.
- R4: With both operands zero and cin_i = 1, sum_o is 1 and cout_o is 0.
- R5: With a_i all ones, b_i zero and cin_i = 1, the carry passes through every group: sum_o is zero and cout_o is 1.
- R6: With a_i and b_i all ones and cin_i = 1, sum_o is all ones and cout_o is 1.
- R7: With a_i all ones, b_i zero and cin_i = 0, no carry appears: sum_o is all ones and cout_o is 0.
- R8: With a_i = b_i = 2^i and cin_i = 0, a carry generated at bit i reaches bit i+1. sum_o is 2^(i+1) for i < WIDTH-1, and cout_o is 1 with sum_o zero for i = WIDTH-1. This holds across every group boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Two things can happen in the same evaluation: a carry is generated inside a group, and a carry arrives at that group's select from below. Both act on the same multiplexer or increment row. Operands that make every bit propagate while cin_i is high, and single-bit generates placed at each group boundary, force these two events to meet. Each result is judged against an arithmetic sum worked out in the bench and also against the other form of the adder.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // number of groups when sizes start at f and grow by one; the last absorbs the rest
  function automatic int n_groups(input int w, input int f);
    int used;
    int k;
    used = 0;
    k = 0;
    for (int i = 0; i < w; i++) begin
      if (used + f + k <= w) begin
        used = used + f + k;
        k = k + 1;
      end
    end
    if (k == 0) k = 1;
    return k;
  endfunction

  function automatic int grp_lo(input int k, input int f);
    return k * f + (k * (k - 1)) / 2;
  endfunction

  function automatic int grp_hi(input int k, input int w, input int f);
    if (k == n_groups(w, f) - 1) return w - 1;
    return grp_lo(k + 1, f) - 1;
  endfunction
endpackage

// File: rtl/csa_pg.sv
module csa_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  always_comb begin
    g_o = a_i & b_i;
    p_o = a_i ^ b_i;
  end
endmodule

// File: rtl/csa_ripple_grp.sv
module csa_ripple_grp #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] g, p;
  logic [W:0]   c;

  csa_pg #(.W(W)) u_pg (.a_i(a_i), .b_i(b_i), .g_o(g), .p_o(p));

  always_comb begin
    c[0] = cin_i;
    for (int i = 0; i < W; i++) c[i+1] = g[i] | (p[i] & c[i]);
    sum_o  = p ^ c[W-1:0];
    cout_o = c[W];
  end

  always_comb begin
    // R5
    ripple_prop_chk: assert (!((&p) && cin_i) || cout_o)
      else $error("full propagate with carry-in lost the carry");
  end
endmodule

// File: rtl/csa_select_grp.sv
module csa_select_grp #(
  parameter int W             = 4,
  parameter bit USE_INCREMENT = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         csel_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  generate
    if (USE_INCREMENT) begin : g_inc
      logic [W-1:0] g, p, gg, pp, c;
      csa_pg #(.W(W)) u_pg (.a_i(a_i), .b_i(b_i), .g_o(g), .p_o(p));

      always_comb begin
        gg[0] = g[0];
        pp[0] = p[0];
        for (int i = 1; i < W; i++) begin
          gg[i] = g[i] | (p[i] & gg[i-1]);
          pp[i] = p[i] & pp[i-1];
        end
        c[0] = csel_i;
        for (int i = 1; i < W; i++) c[i] = gg[i-1] | (pp[i-1] & csel_i);
        sum_o  = p ^ c;
        cout_o = gg[W-1] | (pp[W-1] & csel_i);
      end

      always_comb begin
        // R8
        grp_pg_excl_chk: assert (!(pp[W-1] && gg[W-1]))
          else $error("group both propagates and generates");
      end
    end else begin : g_dup
      logic [W-1:0] sum0, sum1;
      logic         cout0, cout1;
      csa_ripple_grp #(.W(W)) u_lo (.a_i(a_i), .b_i(b_i), .cin_i(1'b0),
                                    .sum_o(sum0), .cout_o(cout0));
      csa_ripple_grp #(.W(W)) u_hi (.a_i(a_i), .b_i(b_i), .cin_i(1'b1),
                                    .sum_o(sum1), .cout_o(cout1));
      always_comb begin
        sum_o  = csel_i ? sum1 : sum0;
        cout_o = csel_i ? cout1 : cout0;
      end

      always_comb begin
        // R8
        carry_mono_chk: assert (!cout0 || cout1)
          else $error("carry with cin=0 but none with cin=1");
      end
    end
  endgenerate
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH         = 16,
  parameter int FIRST_SIZE    = 2,
  parameter bit USE_INCREMENT = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = csa_pkg::n_groups(WIDTH, FIRST_SIZE);
  localparam int EXTW = WIDTH + 1;

  logic [NGRP:0] gc;

  assign gc[0]  = cin_i;
  assign cout_o = gc[NGRP];

  generate
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
      localparam int LO = csa_pkg::grp_lo(k, FIRST_SIZE);
      localparam int HI = csa_pkg::grp_hi(k, WIDTH, FIRST_SIZE);
      localparam int SZ = HI - LO + 1;
      if (k == 0) begin : g_low
        csa_ripple_grp #(.W(SZ)) u_grp (
          .a_i(a_i[HI:LO]), .b_i(b_i[HI:LO]), .cin_i(gc[k]),
          .sum_o(sum_o[HI:LO]), .cout_o(gc[k+1]));
      end else begin : g_up
        csa_select_grp #(.W(SZ), .USE_INCREMENT(USE_INCREMENT)) u_grp (
          .a_i(a_i[HI:LO]), .b_i(b_i[HI:LO]), .csel_i(gc[k]),
          .sum_o(sum_o[HI:LO]), .cout_o(gc[k+1]));
      end
    end
  endgenerate

  always_comb begin
    // R1 (and R2 when USE_INCREMENT is set)
    sum_ok_chk: assert ({cout_o, sum_o} ==
                        EXTW'(a_i) + EXTW'(b_i) + EXTW'(cin_i))
      else $error("adder result differs from arithmetic sum");
  end
endmodule

// File: tb/test_csa_adder.sv
module test_csa_adder;
  localparam int  W          = 16;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [W-1:0] sum;
    logic         cout;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_d, sum_i;
  logic         cout_d, cout_i;
  int           total = 0, bad = 0;
  bit           done = 1'b0;
  exp_t         sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_adder #(.WIDTH(W), .FIRST_SIZE(2), .USE_INCREMENT(1'b0)) i_csa_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_d), .cout_o(cout_d));
  csa_adder #(.WIDTH(W), .FIRST_SIZE(2), .USE_INCREMENT(1'b1)) i_csa_adder_inc (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_i), .cout_o(cout_i));

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string req);
    logic [W:0] full;
    exp_t e;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    full = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    e.sum = full[W-1:0];
    e.cout = full[W];
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor: inputs change on the falling edge, results are taken on the rising edge
  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if ({cout_d, sum_d} !== {e.cout, e.sum}) begin
        bad++;
        $display("FAIL R1/%s select form: got %0b_%h expected %0b_%h",
                 e.req, cout_d, sum_d, e.cout, e.sum);
      end
      total++;
      if ({cout_i, sum_i} !== {e.cout, e.sum}) begin
        bad++;
        $display("FAIL R2/%s increment form: got %0b_%h expected %0b_%h",
                 e.req, cout_i, sum_i, e.cout, e.sum);
      end
      total++;
      if ({cout_d, sum_d} !== {cout_i, sum_i}) begin
        bad++;
        $display("FAIL R3 forms differ: got %0b_%h expected %0b_%h",
                 cout_i, sum_i, cout_d, sum_d);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive('0, '0, 1'b0, "R1 zero");
    drive('0, '0, 1'b1, "R4");
    drive('1, '0, 1'b1, "R5");
    drive('0, '1, 1'b1, "R5");
    drive('1, '1, 1'b1, "R6");
    drive('1, '1, 1'b0, "R6");
    drive('1, '0, 1'b0, "R7");
    for (int i = 0; i < W; i++) begin
      drive(W'(1) << i, W'(1) << i, 1'b0, "R8");
      drive((W'(1) << i) - W'(1), W'(1), 1'b1, "R8 ripple");
    end
    for (int n = 0; n < 400; n++)
      drive(W'($urandom), W'($urandom), 1'($urandom), "R3 random");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule